// File: doc/BRIEF.md
# Dual-CPU Reset Sequencer with Strap Capture

This block controls reset for a two-processor chip and latches the static configuration straps. While the system reset input is low, everything is held: both CPUs, the peripherals, and the isolation of both CPUs. On release, the primary CPU and the peripheral reset are let go after a short synchronizing delay. The secondary CPU stays in reset and isolated. Software running on the primary releases it by clearing that CPU's hold bit.

Each CPU has a level-sensitive software hold bit. Each CPU also has a watchdog expiry input that forces a fixed-length reset pulse. A hold bit that is set wins over the end of a watchdog pulse.

The straps are sampled once, on the first clock edge after system reset is released. They are then presented as:
- a configuration field that software can read;
- a parity/GPIO ownership select;
- a test-mode flag;
- a boot-source select.

A new system reset clears all independent requests and returns the block to its initial state.

Top module: `cpu_pair_rstctl`

## Requirements
- R1: While `sys_rst_n` is low, `cpu_rst_o` and `cpu_iso_o` are all ones and `periph_rst_o` is 1. `cfg_o`, `gpio_bus_own_o`, `bus_parity_en_o`, `test_mode_o` and `boot_serial_o` are 0. Reset assertion is asynchronous.
- R2: Call E0 the first rising clock edge with `sys_rst_n` high. `cpu_rst_o[0]` and `periph_rst_o` are still 1 after E0 and are 0 after E0+1. After that, `periph_rst_o` never rises again until the next system reset.
- R3: `cpu_rst_o[1]` stays 1 after a system reset until software clears hold bit 1. The hold bits come out of reset as bit 0 = 0 and bit 1 = 1.
- R4: A write (`hold_wr_i` high at edge W) loads `hold_wdata_i` into the hold bits, where bit i belongs to CPU i.
  - A hold bit set at W makes that CPU's reset 1 after edge W+1.
  - A hold bit cleared at W lets the reset fall to 0 after W+2, if nothing else requests it.
- R5: Suppose `wdog_expire_i[i]` is high at edge E while CPU i's hold bit is clear. Then `cpu_rst_o[i]` is 1 after each of edges E+1 through E+16 (exactly 16 cycles) and 0 after E+17. The other CPU is not affected.
- R6: A watchdog expiry on a CPU whose hold bit is set does not release it. That CPU's reset stays 1 for as long as the bit is set.
- R7: `cpu_iso_o[i]` is 1 whenever `cpu_rst_o[i]` is 1. It falls exactly one cycle after `cpu_rst_o[i]` falls.
- R8: `cfg_o` equals `strap_cfg_i` as sampled at E0. Later changes on any strap input leave all strap-derived outputs unchanged until the next system reset.
- R9: `gpio_bus_own_o` and `bus_parity_en_o` both equal `strap_parity_i` as sampled at E0. A value of 1 means parity is enabled and the bus controller owns the shared GPIO pins; 0 means they stay ordinary GPIO.
- R10: `test_mode_o` equals `strap_test_i` as sampled at E0. A value of 1 selects internal test mode; 0 selects normal operation.
- R11: `boot_serial_o` equals `strap_boot_i` as sampled at E0. A value of 1 means boot fetch goes to serial interface 0 (EEPROM); 0 means the parallel boot memory.
- R12: A system reset applied during operation overrides every hold and watchdog request. After release, the secondary CPU is held again and the straps are sampled anew.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| sys_rst_n | input | 1 | System / power-on reset, active low, asynchronous assert |
| strap_cfg_i | input | CFG_W | Configuration strap pins for software |
| strap_parity_i | input | 1 | Strap: bus parity enable and GPIO ownership |
| strap_test_i | input | 1 | Strap: internal test mode |
| strap_boot_i | input | 1 | Strap: boot source (1 = serial EEPROM) |
| hold_wr_i | input | 1 | Write strobe for the per-CPU hold bits |
| hold_wdata_i | input | NCPU | New hold bit values, bit i for CPU i |
| wdog_expire_i | input | NCPU | Per-CPU watchdog expiry pulse |
| cpu_rst_o | output | NCPU | Per-CPU reset, active high |
| cpu_iso_o | output | NCPU | Per-CPU isolation from the system, active high |
| periph_rst_o | output | 1 | Peripheral reset, active high |
| cfg_o | output | CFG_W | Captured configuration strap field |
| gpio_bus_own_o | output | 1 | Shared GPIO pins owned by the bus controller |
| bus_parity_en_o | output | 1 | Generic bus parity enable |
| test_mode_o | output | 1 | Internal test mode selected |
| boot_serial_o | output | 1 | Boot fetch from serial interface 0 |

## Verification
The hold bits and the release chains are only visible through `cpu_rst_o` and `cpu_iso_o`.

A hold bit that is wrong shows up two cycles after the offending write. Either the secondary CPU is released too early, or a CPU stays stuck in reset for as long as the bit is wrong. A watchdog counter with a bad load value changes the reset pulse length, and that is visible 16 or 17 cycles after the expiry pulse.

A strap register that is captured at the wrong edge, or recaptured later, shows on the configuration outputs at once. The bench checks these outputs directly after E0 and again after the strap pins have changed.

// File: rtl/cpu_pair_rstctl_pkg.sv
package cpu_pair_rstctl_pkg;

   typedef enum logic {
      BOOT_PARALLEL = 1'b0,
      BOOT_SERIAL   = 1'b1
   } boot_src_e;

   typedef struct packed {
      logic      parity_en;
      logic      test_mode;
      boot_src_e boot_src;
   } strap_ctl_t;

   localparam int unsigned PRIMARY_CPU = 0;

endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic rst_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rst_release_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   // assertion takes effect on the next edge, release walks through the chain
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
      end else if (req_i) begin
         chain_q <= '1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], 1'b0};
      end
   end

   assign rst_o = chain_q[STAGES-1];

endmodule

// File: rtl/wdog_pulse_timer.sv
module wdog_pulse_timer #(
   parameter int unsigned CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_i,
   output logic active_o
);

   generate
      if (CYCLES < 2) begin : g_bad_cycles
         $error("wdog_pulse_timer: CYCLES must be at least 2");
      end
   endgenerate

   localparam int unsigned CNT_W = $clog2(CYCLES);
   // the release chain downstream adds one cycle, so load one less
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (kick_i) begin
         cnt_q <= LOAD_VAL;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign active_o = (cnt_q != '0);

endmodule

// File: rtl/strap_latch.sv
module strap_latch
   import cpu_pair_rstctl_pkg::*;
#(
   parameter int unsigned CFG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg_pins_i,
   input  logic             parity_pin_i,
   input  logic             test_pin_i,
   input  logic             boot_pin_i,
   output logic             taken_o,
   output logic [CFG_W-1:0] cfg_o,
   output strap_ctl_t       ctl_o
);

   generate
      if (CFG_W < 1) begin : g_bad_cfg_w
         $error("strap_latch: CFG_W must be at least 1");
      end
   endgenerate

   logic             taken_q;
   logic [CFG_W-1:0] cfg_q;
   strap_ctl_t       ctl_q;

   // sample once, on the first edge after reset release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taken_q <= 1'b0;
         cfg_q   <= '0;
         ctl_q   <= '0;
      end else if (!taken_q) begin
         taken_q         <= 1'b1;
         cfg_q           <= cfg_pins_i;
         ctl_q.parity_en <= parity_pin_i;
         ctl_q.test_mode <= test_pin_i;
         ctl_q.boot_src  <= boot_pin_i ? BOOT_SERIAL : BOOT_PARALLEL;
      end
   end

   assign taken_o = taken_q;
   assign cfg_o   = cfg_q;
   assign ctl_o   = ctl_q;

endmodule

// File: rtl/cpu_pair_rstctl.sv
module cpu_pair_rstctl
   import cpu_pair_rstctl_pkg::*;
#(
   parameter int unsigned NCPU        = 2,
   parameter int unsigned CFG_W       = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned WDOG_CYCLES = 16
) (
   input  logic             clk,
   input  logic             sys_rst_n,
   input  logic [CFG_W-1:0] strap_cfg_i,
   input  logic             strap_parity_i,
   input  logic             strap_test_i,
   input  logic             strap_boot_i,
   input  logic             hold_wr_i,
   input  logic [NCPU-1:0]  hold_wdata_i,
   input  logic [NCPU-1:0]  wdog_expire_i,
   output logic [NCPU-1:0]  cpu_rst_o,
   output logic [NCPU-1:0]  cpu_iso_o,
   output logic             periph_rst_o,
   output logic [CFG_W-1:0] cfg_o,
   output logic             gpio_bus_own_o,
   output logic             bus_parity_en_o,
   output logic             test_mode_o,
   output logic             boot_serial_o
);

   generate
      if (NCPU < 2) begin : g_bad_ncpu
         $error("cpu_pair_rstctl: NCPU must be at least 2");
      end
   endgenerate

   // primary comes up free, every other CPU waits for software
   localparam logic [NCPU-1:0] HOLD_INIT = {{(NCPU-1){1'b1}}, 1'b0};

   logic [NCPU-1:0] hold_q;
   logic [NCPU-1:0] wd_active;
   logic [NCPU-1:0] lane_req;
   logic [NCPU-1:0] iso_lag_q;
   logic            strap_taken;
   strap_ctl_t      strap_ctl;

   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         hold_q <= HOLD_INIT;
      end else if (hold_wr_i) begin
         hold_q <= hold_wdata_i;
      end
   end

   generate
      for (genvar i = 0; i < NCPU; i++) begin : g_lane
         wdog_pulse_timer #(
            .CYCLES (WDOG_CYCLES)
         ) u_wdog (
            .clk      (clk),
            .rst_n    (sys_rst_n),
            .kick_i   (wdog_expire_i[i]),
            .active_o (wd_active[i])
         );

         assign lane_req[i] = hold_q[i] | wd_active[i];

         rst_release_sync #(
            .STAGES (SYNC_STAGES)
         ) u_sync (
            .clk   (clk),
            .rst_n (sys_rst_n),
            .req_i (lane_req[i]),
            .rst_o (cpu_rst_o[i])
         );
      end
   endgenerate

   // isolation rises with reset and drops one cycle after it
   always_ff @(posedge clk or negedge sys_rst_n) begin
      if (!sys_rst_n) begin
         iso_lag_q <= '1;
      end else begin
         iso_lag_q <= cpu_rst_o;
      end
   end

   assign cpu_iso_o = cpu_rst_o | iso_lag_q;

   rst_release_sync #(
      .STAGES (SYNC_STAGES)
   ) u_periph_sync (
      .clk   (clk),
      .rst_n (sys_rst_n),
      .req_i (1'b0),
      .rst_o (periph_rst_o)
   );

   strap_latch #(
      .CFG_W (CFG_W)
   ) u_strap (
      .clk          (clk),
      .rst_n        (sys_rst_n),
      .cfg_pins_i   (strap_cfg_i),
      .parity_pin_i (strap_parity_i),
      .test_pin_i   (strap_test_i),
      .boot_pin_i   (strap_boot_i),
      .taken_o      (strap_taken),
      .cfg_o        (cfg_o),
      .ctl_o        (strap_ctl)
   );

   assign gpio_bus_own_o  = strap_ctl.parity_en;
   assign bus_parity_en_o = strap_ctl.parity_en;
   assign test_mode_o     = strap_ctl.test_mode;
   assign boot_serial_o   = (strap_ctl.boot_src == BOOT_SERIAL);

endmodule

// File: rtl/cpu_pair_rstctl_chk.sv
module cpu_pair_rstctl_chk #(
   parameter int unsigned NCPU  = 2,
   parameter int unsigned CFG_W = 6
) (
   input logic             clk,
   input logic             sys_rst_n,
   input logic [NCPU-1:0]  wdog_expire_i,
   input logic [NCPU-1:0]  hold_q,
   input logic             strap_taken,
   input logic [NCPU-1:0]  cpu_rst_o,
   input logic [NCPU-1:0]  cpu_iso_o,
   input logic             periph_rst_o,
   input logic [CFG_W-1:0] cfg_o,
   input logic             gpio_bus_own_o,
   input logic             bus_parity_en_o,
   input logic             test_mode_o,
   input logic             boot_serial_o
);

   generate
      for (genvar i = 0; i < NCPU; i++) begin : g_lane_chk
         // R7: isolation covers the whole reset
         p_iso_covers_rst_r7: assert property (@(posedge clk) disable iff (!sys_rst_n)
            cpu_rst_o[i] |-> cpu_iso_o[i]);

         // R7: isolation lifted once reset has been low for a cycle
         p_iso_lifts_r7: assert property (@(posedge clk) disable iff (!sys_rst_n)
            (!cpu_rst_o[i] && $past(!cpu_rst_o[i])) |-> !cpu_iso_o[i]);

         // R5: watchdog expiry reaches the reset line two edges later
         p_wdog_asserts_r5: assert property (@(posedge clk) disable iff (!sys_rst_n)
            wdog_expire_i[i] |-> ##2 cpu_rst_o[i]);

         // R6: a set hold bit keeps the CPU in reset
         p_hold_keeps_rst_r6: assert property (@(posedge clk) disable iff (!sys_rst_n)
            $past(hold_q[i]) |-> cpu_rst_o[i]);
      end
   endgenerate

   // R2: peripherals never re-enter reset without a system reset
   p_periph_once_r2: assert property (@(posedge clk) disable iff (!sys_rst_n)
      !periph_rst_o |=> !periph_rst_o);

   // R8: captured straps stay frozen
   p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!sys_rst_n)
      (strap_taken && $past(strap_taken)) |->
         ($stable(cfg_o) && $stable(gpio_bus_own_o) && $stable(bus_parity_en_o)
          && $stable(test_mode_o) && $stable(boot_serial_o)));

endmodule

bind cpu_pair_rstctl cpu_pair_rstctl_chk #(
   .NCPU  (NCPU),
   .CFG_W (CFG_W)
) u_chk (
   .clk             (clk),
   .sys_rst_n       (sys_rst_n),
   .wdog_expire_i   (wdog_expire_i),
   .hold_q          (hold_q),
   .strap_taken     (strap_taken),
   .cpu_rst_o       (cpu_rst_o),
   .cpu_iso_o       (cpu_iso_o),
   .periph_rst_o    (periph_rst_o),
   .cfg_o           (cfg_o),
   .gpio_bus_own_o  (gpio_bus_own_o),
   .bus_parity_en_o (bus_parity_en_o),
   .test_mode_o     (test_mode_o),
   .boot_serial_o   (boot_serial_o)
);

// File: tb/cpu_pair_rstctl_tb.sv
`timescale 1ns/1ps
module cpu_pair_rstctl_tb;

   localparam int NCPU  = 2;
   localparam int CFG_W = 6;

   logic             clk = 1'b0;
   logic             sys_rst_n = 1'b0;
   logic [CFG_W-1:0] strap_cfg_i = '0;
   logic             strap_parity_i = 1'b0;
   logic             strap_test_i = 1'b0;
   logic             strap_boot_i = 1'b0;
   logic             hold_wr_i = 1'b0;
   logic [NCPU-1:0]  hold_wdata_i = '0;
   logic [NCPU-1:0]  wdog_expire_i = '0;
   logic [NCPU-1:0]  cpu_rst_o;
   logic [NCPU-1:0]  cpu_iso_o;
   logic             periph_rst_o;
   logic [CFG_W-1:0] cfg_o;
   logic             gpio_bus_own_o;
   logic             bus_parity_en_o;
   logic             test_mode_o;
   logic             boot_serial_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   cpu_pair_rstctl u_dut (
      .clk             (clk),
      .sys_rst_n       (sys_rst_n),
      .strap_cfg_i     (strap_cfg_i),
      .strap_parity_i  (strap_parity_i),
      .strap_test_i    (strap_test_i),
      .strap_boot_i    (strap_boot_i),
      .hold_wr_i       (hold_wr_i),
      .hold_wdata_i    (hold_wdata_i),
      .wdog_expire_i   (wdog_expire_i),
      .cpu_rst_o       (cpu_rst_o),
      .cpu_iso_o       (cpu_iso_o),
      .periph_rst_o    (periph_rst_o),
      .cfg_o           (cfg_o),
      .gpio_bus_own_o  (gpio_bus_own_o),
      .bus_parity_en_o (bus_parity_en_o),
      .test_mode_o     (test_mode_o),
      .boot_serial_o   (boot_serial_o)
   );

   localparam logic [CFG_W-1:0] CFG_A = 6'b101101;
   localparam logic [CFG_W-1:0] CFG_B = 6'b010011;

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic set_straps(logic [CFG_W-1:0] c, logic p, logic t, logic b);
      strap_cfg_i    = c;
      strap_parity_i = p;
      strap_test_i   = t;
      strap_boot_i   = b;
   endtask

   task automatic write_hold(logic [NCPU-1:0] v);
      hold_wr_i    = 1'b1;
      hold_wdata_i = v;
      step();
      hold_wr_i    = 1'b0;
   endtask

   task automatic t_reset_state();
      set_straps(CFG_A, 1'b1, 1'b0, 1'b1);
      repeat (3) step();
      check("R1", "cpu_rst in reset", 32'(cpu_rst_o), 32'h3);
      check("R1", "cpu_iso in reset", 32'(cpu_iso_o), 32'h3);
      check("R1", "periph_rst in reset", 32'(periph_rst_o), 32'h1);
      check("R1", "cfg in reset", 32'(cfg_o), 32'h0);
      check("R1", "strap flags in reset",
            32'({gpio_bus_own_o, bus_parity_en_o, test_mode_o, boot_serial_o}), 32'h0);
   endtask

   task automatic t_boot_release();
      sys_rst_n = 1'b1;
      step(); // E0
      check("R2", "cpu_rst after E0", 32'(cpu_rst_o), 32'h3);
      check("R2", "periph after E0", 32'(periph_rst_o), 32'h1);
      check("R8", "cfg captured", 32'(cfg_o), 32'(CFG_A));
      check("R9", "parity/gpio own high", 32'({gpio_bus_own_o, bus_parity_en_o}), 32'h3);
      check("R10", "test mode low", 32'(test_mode_o), 32'h0);
      check("R11", "boot serial high", 32'(boot_serial_o), 32'h1);
      step(); // E0+1
      check("R2", "primary released", 32'(cpu_rst_o[0]), 32'h0);
      check("R2", "periph released", 32'(periph_rst_o), 32'h0);
      check("R3", "secondary held", 32'(cpu_rst_o[1]), 32'h1);
      check("R7", "iso lags release", 32'(cpu_iso_o), 32'h3);
      step();
      check("R7", "iso lifted on primary", 32'(cpu_iso_o), 32'h2);
      repeat (10) step();
      check("R3", "secondary still held", 32'(cpu_rst_o), 32'h2);
   endtask

   task automatic t_strap_ignored();
      set_straps(CFG_B, 1'b0, 1'b1, 1'b0);
      repeat (5) step();
      check("R8", "cfg unchanged", 32'(cfg_o), 32'(CFG_A));
      check("R8", "flags unchanged",
            32'({gpio_bus_own_o, bus_parity_en_o, test_mode_o, boot_serial_o}), 32'hD);
   endtask

   task automatic t_release_secondary();
      write_hold(2'b00); // edge W
      check("R4", "secondary after W", 32'(cpu_rst_o[1]), 32'h1);
      step();
      check("R4", "secondary after W+1", 32'(cpu_rst_o[1]), 32'h1);
      step();
      check("R3", "secondary released W+2", 32'(cpu_rst_o[1]), 32'h0);
      check("R7", "secondary iso lagging", 32'(cpu_iso_o[1]), 32'h1);
      step();
      check("R7", "secondary iso lifted", 32'(cpu_iso_o[1]), 32'h0);
   endtask

   task automatic t_sw_reset_primary();
      write_hold(2'b01);
      check("R4", "primary not yet reset after W", 32'(cpu_rst_o[0]), 32'h0);
      step();
      check("R4", "primary reset after W+1", 32'(cpu_rst_o), 32'h1);
      repeat (5) step();
      check("R4", "primary held by level bit", 32'(cpu_rst_o[0]), 32'h1);
      check("R2", "periph unaffected", 32'(periph_rst_o), 32'h0);
      write_hold(2'b00);
      step();
      check("R4", "primary still reset W+1", 32'(cpu_rst_o[0]), 32'h1);
      step();
      check("R4", "primary released W+2", 32'(cpu_rst_o[0]), 32'h0);
      step();
   endtask

   task automatic t_wdog_primary();
      int bad = 0;
      wdog_expire_i = 2'b01;
      step(); // E
      wdog_expire_i = 2'b00;
      check("R5", "no reset right after E", 32'(cpu_rst_o[0]), 32'h0);
      for (int k = 1; k <= 16; k++) begin
         step();
         if (cpu_rst_o !== 2'b01) bad++;
      end
      check("R5", "16-cycle pulse, other CPU free (mismatch count)", 32'(bad), 32'h0);
      step();
      check("R5", "released after E+17", 32'(cpu_rst_o[0]), 32'h0);
   endtask

   task automatic t_wdog_held();
      write_hold(2'b10);
      repeat (3) step();
      check("R4", "secondary re-held", 32'(cpu_rst_o[1]), 32'h1);
      wdog_expire_i = 2'b10;
      step();
      wdog_expire_i = 2'b00;
      repeat (25) step();
      check("R6", "held CPU stays in reset after watchdog", 32'(cpu_rst_o[1]), 32'h1);
      check("R6", "held CPU stays isolated", 32'(cpu_iso_o[1]), 32'h1);
      write_hold(2'b00);
      step();
      step();
      check("R6", "released once hold cleared", 32'(cpu_rst_o[1]), 32'h0);
   endtask

   task automatic t_sysreset_again();
      set_straps(CFG_B, 1'b0, 1'b1, 1'b0);
      sys_rst_n = 1'b0;
      #1;
      check("R12", "async reset all CPUs", 32'(cpu_rst_o), 32'h3);
      check("R12", "async periph reset", 32'(periph_rst_o), 32'h1);
      check("R1", "cfg cleared in reset", 32'(cfg_o), 32'h0);
      step();
      step();
      sys_rst_n = 1'b1;
      step(); // E0
      check("R8", "new cfg captured", 32'(cfg_o), 32'(CFG_B));
      check("R9", "parity/gpio own low", 32'({gpio_bus_own_o, bus_parity_en_o}), 32'h0);
      check("R10", "test mode high", 32'(test_mode_o), 32'h1);
      check("R11", "boot parallel", 32'(boot_serial_o), 32'h0);
      step();
      check("R12", "secondary held again", 32'(cpu_rst_o), 32'h2);
      repeat (10) step();
      check("R12", "secondary still held", 32'(cpu_rst_o), 32'h2);
   endtask

   initial begin
      t_reset_state();
      t_boot_release();
      t_strap_ignored();
      t_release_secondary();
      t_sw_reset_primary();
      t_wdog_primary();
      t_wdog_held();
      t_sysreset_again();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule